// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block decides where each of the two ALU operands in the execute stage of a five-stage in-order integer pipeline comes from. An operand can be the value read from the register file during decode. It can also be the result still held in the execute/memory stage register, or the result held in the memory/writeback stage register. The decision compares the operand's source register number with the destination register number and write enable of the two later stages. It is purely combinational, so the selects are valid in the same cycle that the instruction sits in execute.

The selector is wrapped in a thin pipeline shell so that it can be exercised on real data. The shell has:
- a decode/execute register holding the source register numbers, the register-file values, the destination and the write enable;
- one three-way multiplexer per operand;
- an adder standing in for the ALU;
- two result-carrying stage registers that model execute/memory and memory/writeback.

Stall detection, forwarding into decode for branches, and the register file itself are not part of the block.

Top module: `pipe_fwd_core`

## Requirements
- R1: Each operand select is 2 bits wide. The code 2'b00 delivers the register-file value, 2'b10 delivers the execute/memory result, and 2'b01 delivers the memory/writeback result. The code 2'b11 never appears.
- R2: An operand takes the execute/memory result when that stage's write enable is 1, its destination is nonzero, and its destination equals the operand's source register.
- R3: An operand takes the memory/writeback result when that stage's write enable is 1, its destination is nonzero, its destination equals the operand's source register, and the R2 condition is false for the same operand.
- R4: When both later stages write the operand's source register, the execute/memory result (the younger producer) is selected.
- R5: Operand A (first source) and operand B (second source) follow identical rules, each evaluated on its own. Both may select the same stage in the same cycle.
- R6: A destination of register 0 never causes forwarding, even with its write enable set.
- R7: The selects and the operand values follow the stage registers with no added clock cycle. When no condition holds, the select is 2'b00.
- R8: In the shell, the execute result is the sum of the two selected operands. That result, with its destination and write enable, moves into the execute/memory register at the next clock edge and into the memory/writeback register one edge later.
- R9: While reset is low, every stage register is cleared. Write enables become 0, so the selects read 2'b00 and the operands and result read zero. An instruction issued just after reset sees no forwarding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_src_a | input | REG_W | First source register of the instruction leaving decode |
| id_src_b | input | REG_W | Second source register of the instruction leaving decode |
| id_val_a | input | DATA_W | Register-file value read for the first source |
| id_val_b | input | DATA_W | Register-file value read for the second source |
| id_dst | input | REG_W | Destination register of the instruction leaving decode |
| id_wen | input | 1 | Register-write enable of the instruction leaving decode |
| ex_sel_a | output | 2 | Source select for operand A in execute |
| ex_sel_b | output | 2 | Source select for operand B in execute |
| ex_opnd_a | output | DATA_W | Operand A value after the bypass multiplexer |
| ex_opnd_b | output | DATA_W | Operand B value after the bypass multiplexer |
| ex_result | output | DATA_W | Sum of the two selected operands |

## Verification
A fault in the match logic shows at the ports in the very cycle the consuming instruction sits in execute. The select code is wrong there, and the operand value shows the stale register-file value or the older producer's result. The corrupted sum also reappears as a wrong operand one or two cycles later, whenever a later instruction consumes it. A fault in the stage registers shows instead as a wrong forwarded value one cycle after the producer leaves execute. The three-writer chain on one register separates an inverted priority from a correct one, because the two candidate results differ.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_MWB = 2'b01,
        FWD_EXM = 2'b10
    } fwd_sel_e;

endpackage

// File: rtl/fwd_match.sv
module fwd_match
    import fwd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] exm_dst,
    input  logic             exm_wen,
    input  logic [REG_W-1:0] mwb_dst,
    input  logic             mwb_wen,
    output logic [1:0]       sel
);

    logic     exm_hit;
    logic     mwb_hit;
    fwd_sel_e pick;

    always_comb begin
        exm_hit = exm_wen && (exm_dst != '0) && (exm_dst == src);
        mwb_hit = mwb_wen && (mwb_dst != '0) && (mwb_dst == src);
        if (exm_hit) begin
            pick = FWD_EXM;
        end else if (mwb_hit) begin
            pick = FWD_MWB;
        end else begin
            pick = FWD_RF;
        end
        sel = pick;
    end

endmodule

// File: rtl/fwd_sel_unit.sv
module fwd_sel_unit #(
    parameter int REG_W   = 5,
    parameter int NUM_OPS = 2
) (
    input  logic [NUM_OPS-1:0][REG_W-1:0] src,
    input  logic [REG_W-1:0]              exm_dst,
    input  logic                          exm_wen,
    input  logic [REG_W-1:0]              mwb_dst,
    input  logic                          mwb_wen,
    output logic [NUM_OPS-1:0][1:0]       sel
);

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        fwd_match #(.REG_W(REG_W)) u_match (
            .src     (src[g]),
            .exm_dst (exm_dst),
            .exm_wen (exm_wen),
            .mwb_dst (mwb_dst),
            .mwb_wen (mwb_wen),
            .sel     (sel[g])
        );
    end

endmodule

// File: rtl/operand_mux.sv
module operand_mux
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] exm_val,
    input  logic [DATA_W-1:0] mwb_val,
    output logic [DATA_W-1:0] opnd
);

    always_comb begin
        case (sel)
            FWD_EXM: opnd = exm_val;
            FWD_MWB: opnd = mwb_val;
            default: opnd = rf_val;
        endcase
    end

endmodule

// File: rtl/pipe_fwd_core.sv
module pipe_fwd_core
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REG_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  id_src_a,
    input  logic [REG_W-1:0]  id_src_b,
    input  logic [DATA_W-1:0] id_val_a,
    input  logic [DATA_W-1:0] id_val_b,
    input  logic [REG_W-1:0]  id_dst,
    input  logic              id_wen,
    output logic [1:0]        ex_sel_a,
    output logic [1:0]        ex_sel_b,
    output logic [DATA_W-1:0] ex_opnd_a,
    output logic [DATA_W-1:0] ex_opnd_b,
    output logic [DATA_W-1:0] ex_result
);

    localparam int NUM_OPS = 2;

    typedef struct packed {
        logic [REG_W-1:0]  src_a;
        logic [REG_W-1:0]  src_b;
        logic [DATA_W-1:0] val_a;
        logic [DATA_W-1:0] val_b;
        logic [REG_W-1:0]  dst;
        logic              wen;
    } de_stage_t;

    typedef struct packed {
        logic [REG_W-1:0]  dst;
        logic              wen;
        logic [DATA_W-1:0] res;
    } res_stage_t;

    typedef struct packed {
        de_stage_t  de;
        res_stage_t exm;
        res_stage_t mwb;
    } pipe_t;

    pipe_t st_d;
    pipe_t st_q;

    logic [NUM_OPS-1:0][REG_W-1:0]  src_arr;
    logic [NUM_OPS-1:0][DATA_W-1:0] rf_arr;
    logic [NUM_OPS-1:0][1:0]        sel_arr;
    logic [NUM_OPS-1:0][DATA_W-1:0] opnd_arr;
    logic [DATA_W-1:0]              alu_res;

    assign src_arr[0] = st_q.de.src_a;
    assign src_arr[1] = st_q.de.src_b;
    assign rf_arr[0]  = st_q.de.val_a;
    assign rf_arr[1]  = st_q.de.val_b;

    fwd_sel_unit #(.REG_W(REG_W), .NUM_OPS(NUM_OPS)) u_sel (
        .src     (src_arr),
        .exm_dst (st_q.exm.dst),
        .exm_wen (st_q.exm.wen),
        .mwb_dst (st_q.mwb.dst),
        .mwb_wen (st_q.mwb.wen),
        .sel     (sel_arr)
    );

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_mux
        operand_mux #(.DATA_W(DATA_W)) u_mux (
            .sel     (sel_arr[g]),
            .rf_val  (rf_arr[g]),
            .exm_val (st_q.exm.res),
            .mwb_val (st_q.mwb.res),
            .opnd    (opnd_arr[g])
        );
    end

    assign alu_res = opnd_arr[0] + opnd_arr[1];

    always_comb begin
        st_d           = st_q;
        st_d.de.src_a  = id_src_a;
        st_d.de.src_b  = id_src_b;
        st_d.de.val_a  = id_val_a;
        st_d.de.val_b  = id_val_b;
        st_d.de.dst    = id_dst;
        st_d.de.wen    = id_wen;
        st_d.exm.dst   = st_q.de.dst;
        st_d.exm.wen   = st_q.de.wen;
        st_d.exm.res   = alu_res;
        st_d.mwb       = st_q.exm;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ex_sel_a  = sel_arr[0];
    assign ex_sel_b  = sel_arr[1];
    assign ex_opnd_a = opnd_arr[0];
    assign ex_opnd_b = opnd_arr[1];
    assign ex_result = alu_res;

    // Per-operand checks on the selector and the multiplexer it steers
    for (genvar g = 0; g < NUM_OPS; g++) begin : g_chk
        p_sel_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
            sel_arr[g] != 2'b11);

        p_exm_path_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_arr[g] == 2'b10) |->
                (st_q.exm.wen && st_q.exm.dst == src_arr[g] && opnd_arr[g] == st_q.exm.res));

        p_mwb_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_arr[g] == 2'b01) |->
                (st_q.mwb.wen && st_q.mwb.dst == src_arr[g] && st_q.mwb.dst != '0
                 && opnd_arr[g] == st_q.mwb.res));

        p_young_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.exm.wen && st_q.mwb.wen && src_arr[g] != '0
             && st_q.exm.dst == src_arr[g] && st_q.mwb.dst == src_arr[g])
                |-> (opnd_arr[g] == st_q.exm.res));

        p_zero_reg_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (src_arr[g] == '0) |-> (opnd_arr[g] == rf_arr[g]));

        p_default_rf_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (!(st_q.exm.wen && st_q.exm.dst == src_arr[g])
             && !(st_q.mwb.wen && st_q.mwb.dst == src_arr[g]))
                |-> (sel_arr[g] == 2'b00 && opnd_arr[g] == rf_arr[g]));
    end

    p_result_moves_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.exm.res == $past(ex_result)));

endmodule

// File: tb/sim_pipe_fwd_core.sv
`timescale 1ns/100ps
module sim_pipe_fwd_core;

    localparam int DATA_W = 32;
    localparam int REG_W  = 5;
    localparam int NVEC   = 13;

    typedef struct packed {
        logic [REG_W-1:0]  sa;
        logic [REG_W-1:0]  sb;
        logic [DATA_W-1:0] va;
        logic [DATA_W-1:0] vb;
        logic [REG_W-1:0]  dst;
        logic              wen;
        logic [1:0]        e_sa;
        logic [1:0]        e_sb;
        logic [DATA_W-1:0] e_a;
        logic [DATA_W-1:0] e_b;
        logic [DATA_W-1:0] e_res;
    } vec_t;

    // Each row: issued instruction, then what execute shows one edge later
    localparam vec_t VEC [NVEC] = '{
        '{5'd1,  5'd2,  32'd10,  32'd20, 5'd3,  1'b1, 2'b00, 2'b00, 32'd10,  32'd20,  32'd30},
        '{5'd3,  5'd4,  32'd100, 32'd40, 5'd5,  1'b1, 2'b10, 2'b00, 32'd30,  32'd40,  32'd70},
        '{5'd5,  5'd3,  32'd7,   32'd8,  5'd6,  1'b1, 2'b10, 2'b01, 32'd70,  32'd30,  32'd100},
        '{5'd6,  5'd6,  32'd1,   32'd2,  5'd0,  1'b1, 2'b10, 2'b10, 32'd100, 32'd100, 32'd200},
        '{5'd0,  5'd6,  32'd9,   32'd11, 5'd7,  1'b0, 2'b00, 2'b01, 32'd9,   32'd100, 32'd109},
        '{5'd0,  5'd0,  32'd5,   32'd6,  5'd0,  1'b1, 2'b00, 2'b00, 32'd5,   32'd6,   32'd11},
        '{5'd7,  5'd0,  32'd12,  32'd13, 5'd8,  1'b1, 2'b00, 2'b00, 32'd12,  32'd13,  32'd25},
        '{5'd20, 5'd21, 32'd1,   32'd2,  5'd9,  1'b1, 2'b00, 2'b00, 32'd1,   32'd2,   32'd3},
        '{5'd22, 5'd23, 32'd4,   32'd5,  5'd9,  1'b1, 2'b00, 2'b00, 32'd4,   32'd5,   32'd9},
        '{5'd9,  5'd9,  32'd50,  32'd60, 5'd9,  1'b1, 2'b10, 2'b10, 32'd9,   32'd9,   32'd18},
        '{5'd9,  5'd1,  32'd70,  32'd80, 5'd10, 1'b1, 2'b10, 2'b00, 32'd18,  32'd80,  32'd98},
        '{5'd10, 5'd9,  32'd3,   32'd4,  5'd11, 1'b0, 2'b10, 2'b01, 32'd98,  32'd18,  32'd116},
        '{5'd10, 5'd11, 32'd5,   32'd6,  5'd0,  1'b0, 2'b01, 2'b00, 32'd98,  32'd6,   32'd104}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [REG_W-1:0]  id_src_a = '0;
    logic [REG_W-1:0]  id_src_b = '0;
    logic [DATA_W-1:0] id_val_a = '0;
    logic [DATA_W-1:0] id_val_b = '0;
    logic [REG_W-1:0]  id_dst = '0;
    logic              id_wen = 1'b0;
    logic [1:0]        ex_sel_a;
    logic [1:0]        ex_sel_b;
    logic [DATA_W-1:0] ex_opnd_a;
    logic [DATA_W-1:0] ex_opnd_b;
    logic [DATA_W-1:0] ex_result;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    pipe_fwd_core #(.DATA_W(DATA_W), .REG_W(REG_W)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .id_src_a  (id_src_a),
        .id_src_b  (id_src_b),
        .id_val_a  (id_val_a),
        .id_val_b  (id_val_b),
        .id_dst    (id_dst),
        .id_wen    (id_wen),
        .ex_sel_a  (ex_sel_a),
        .ex_sel_b  (ex_sel_b),
        .ex_opnd_a (ex_opnd_a),
        .ex_opnd_b (ex_opnd_b),
        .ex_result (ex_result)
    );

    task automatic chk(input string req, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic issue(input logic [REG_W-1:0] sa, input logic [REG_W-1:0] sb,
                         input logic [DATA_W-1:0] va, input logic [DATA_W-1:0] vb,
                         input logic [REG_W-1:0] dst, input logic wen);
        @(negedge clk);
        id_src_a = sa;
        id_src_b = sb;
        id_val_a = va;
        id_val_b = vb;
        id_dst   = dst;
        id_wen   = wen;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(5 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        // R9: reset state visible at the ports
        repeat (3) @(posedge clk);
        #1;
        chk("R9", "reset sel_a", {30'd0, ex_sel_a}, 0);
        chk("R9", "reset sel_b", {30'd0, ex_sel_b}, 0);
        chk("R9", "reset result", ex_result, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1..R8: table walk; rows 9 and 10 form the three-writer chain on register 9
        for (int i = 0; i < NVEC; i++) begin
            issue(VEC[i].sa, VEC[i].sb, VEC[i].va, VEC[i].vb, VEC[i].dst, VEC[i].wen);
            chk("R1/R2/R3/R4/R5/R6/R7", $sformatf("row %0d sel_a", i), {30'd0, ex_sel_a}, {30'd0, VEC[i].e_sa});
            chk("R1/R2/R3/R4/R5/R6/R7", $sformatf("row %0d sel_b", i), {30'd0, ex_sel_b}, {30'd0, VEC[i].e_sb});
            chk("R1/R5", $sformatf("row %0d opnd_a", i), ex_opnd_a, VEC[i].e_a);
            chk("R1/R5", $sformatf("row %0d opnd_b", i), ex_opnd_b, VEC[i].e_b);
            chk("R8", $sformatf("row %0d result", i), ex_result, VEC[i].e_res);
        end

        // R4: middle writer of the chain (value 9) beat the oldest (value 3) on row 9
        chk("R4", "chain middle producer", VEC[9].e_a, 32'd9);

        // R9: reset in mid-run clears the stages even with a matching instruction waiting
        @(negedge clk);
        id_src_a = 5'd9;
        id_src_b = 5'd9;
        rst_n    = 1'b0;
        @(posedge clk);
        #1;
        chk("R9", "mid reset sel_a", {30'd0, ex_sel_a}, 0);
        chk("R9", "mid reset opnd_b", ex_opnd_b, 0);
        chk("R9", "mid reset result", ex_result, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: first instruction after reset reads the register file
        issue(5'd9, 5'd9, 32'd77, 32'd88, 5'd9, 1'b1);
        chk("R9", "post reset sel_a", {30'd0, ex_sel_a}, 0);
        chk("R9", "post reset opnd_a", ex_opnd_a, 32'd77);
        chk("R9", "post reset result", ex_result, 32'd165);

        // R2: next reader of register 9 sees 165 from execute/memory
        issue(5'd9, 5'd0, 32'd1, 32'd2, 5'd0, 1'b0);
        chk("R2", "after reset exm sel_a", {30'd0, ex_sel_a}, 2);
        chk("R2", "after reset exm opnd_a", ex_opnd_a, 32'd165);
        chk("R6", "src zero opnd_b", ex_opnd_b, 32'd2);

        finish_run();
    end

endmodule